// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block sets the pace of a successive-approximation converter. It divides the system clock down to an ADC clock, and from that it derives a second clock at half that rate. Each conversion fires one sample-and-hold strobe. Ten bit trials follow, and each trial drives a trial code to the DAC and reads back an external comparator bit. The block then latches a 10-bit result and sets a sticky done flag.

A conversion can start in three ways: a CPU write of the start bit, an auto-trigger pulse, or a free-running restart. The conversion type sets both the length and the sample instant. The types are: the first conversion after enable, a normal single-ended conversion, an auto-triggered conversion, and a differential conversion. A differential conversion aligns to the phase of the half-rate clock.

The channel/reference select is written to a temporary register. It reaches the active select only while no conversion holds it locked.

Top module: `adc_conv_seq`

## Requirements
- R1: `adc_clk` is low for `CLK_HALF` system clocks and high for `CLK_HALF` system clocks. `sync_clk` toggles on every rising edge of `adc_clk`. While `en` is low, both clocks are held low.
- R2: A CPU start on a single-ended channel begins at the first `adc_clk` rising edge strictly after the write. The strobe comes 1.5 ADC cycles (3 half cycles) after that edge, and the done flag 13 ADC cycles (26 half cycles) after it.
- R3: The first conversion after `en` rises takes 25 ADC cycles, with the strobe at 13.5 cycles. This timing applies whatever the other inputs are.
- R4: When `auto_trig` is high with the block idle, the prescaler restarts in that cycle and the conversion starts in that cycle. The strobe follows 2 ADC cycles later and done follows 13.5 ADC cycles later.
- R5: A CPU start with `diff_mode`=1 takes 13 cycles with the strobe at 1.5 if `sync_clk` was low just before the starting edge. It takes 14 cycles with the strobe at 2.5 if `sync_clk` was high.
- R6: With `free_run`=1, a new conversion starts on the same edge that sets done. Each restart takes 14 cycles (strobe at 2.5) when `diff_mode`=1, and 13 cycles (strobe at 1.5) otherwise.
- R7: Ten trials run MSB first. `dac_code` shows the kept bits plus the bit on trial. A bit is kept when `cmp_keep`=1. `result` is therefore the largest code with `cmp_keep` true.
- R8: `start_busy` reads 1 from the start write until done is set. `done_flag` and `result` update on the same edge. `done_flag` stays set until `done_clr`, and a set wins over a clear in the same cycle.
- R9: The active select follows the temporary register while idle. It is frozen from conversion start and resumes copying in the last ADC cycle before done.
- R10: With `en`=0, any conversion is aborted and start writes are ignored. The next conversion after re-enable is a first conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable |
| start_wr | input | 1 | CPU write of 1 to the start bit |
| auto_trig | input | 1 | Auto-trigger pulse |
| free_run | input | 1 | Free-running mode |
| diff_mode | input | 1 | 1 = differential channel |
| done_clr | input | 1 | CPU write of 1 to clear done |
| sel_wr | input | 1 | Write strobe for the temporary select |
| sel_wdata | input | SEL_W | Channel/reference select value |
| cmp_keep | input | 1 | Comparator: input is at or above the trial code |
| adc_clk | output | 1 | Prescaled ADC clock |
| sync_clk | output | 1 | Half-rate alignment clock |
| sh_strobe | output | 1 | Sample-and-hold strobe, one system clock |
| dac_code | output | RES_W | Current trial code |
| done_flag | output | 1 | Sticky conversion-complete flag |
| start_busy | output | 1 | Start bit readback |
| result | output | RES_W | Last conversion result |
| active_sel | output | SEL_W | Active channel/reference select |

## Verification
Completion sets `done_flag`, and a CPU `done_clr` clears it; the two can land on the same system clock. An auto-trigger makes the completion edge exactly predictable: it falls 27 half cycles after the trigger edge. The bench therefore raises `done_clr` so that it is sampled on that very edge. It then expects `done_flag` to read 1 on that cycle and the cycle after, while the scoreboard still matches the result and timing of that conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int TM_W = 7;

  typedef enum logic [1:0] {
    KIND_BASE,
    KIND_LONG,
    KIND_AUTO,
    KIND_WARM
  } conv_kind_t;

  // Timeline of one conversion in half ADC cycles from its start point.
  typedef struct packed {
    logic [TM_W-1:0] sh_at;
    logic [TM_W-1:0] end_at;
  } conv_tm_t;

  function automatic conv_tm_t tm_of(conv_kind_t k);
    conv_tm_t t;
    case (k)
      KIND_LONG: begin t.sh_at = TM_W'(5);  t.end_at = TM_W'(28); end
      KIND_AUTO: begin t.sh_at = TM_W'(4);  t.end_at = TM_W'(27); end
      KIND_WARM: begin t.sh_at = TM_W'(27); t.end_at = TM_W'(50); end
      default:   begin t.sh_at = TM_W'(3);  t.end_at = TM_W'(26); end
    endcase
    return t;
  endfunction
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic resync,
  output logic tick,
  output logic rise,
  output logic adc_clk,
  output logic half_clk
);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [PW-1:0] LAST = PW'(HALF - 1);

  logic [PW-1:0] pcnt;

  assign tick = !hold && !resync && (pcnt == LAST);
  assign rise = tick && !adc_clk;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      pcnt     <= '0;
      adc_clk  <= 1'b0;
      half_clk <= 1'b0;
    end else if (resync) begin
      pcnt    <= '0;
      adc_clk <= 1'b0;
    end else begin
      pcnt <= tick ? '0 : pcnt + 1'b1;
      if (tick) adc_clk <= ~adc_clk;
      if (rise) half_clk <= ~half_clk;
    end
  end

  assert_clk_edges_R1: assert property (@(posedge clk) disable iff (rst)
    !$stable(adc_clk) |-> $past(tick || hold || resync));
  assert_half_edges_R1: assert property (@(posedge clk) disable iff (rst)
    !$stable(half_clk) |-> $past(rise || hold));
  assert_hold_low_R10: assert property (@(posedge clk) disable iff (rst)
    hold |=> !adc_clk && !half_clk);
endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic         keep,
  output logic [W-1:0] trial,
  output logic [W-1:0] code
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] approx;
  logic [W-1:0] probe;

  always_ff @(posedge clk) begin
    if (rst) begin
      approx <= '0;
      probe  <= '0;
    end else if (load) begin
      approx <= '0;
      probe  <= TOP_BIT;
    end else if (step) begin
      if (keep) approx <= approx | probe;
      probe <= probe >> 1;
    end
  end

  assign trial = approx | probe;
  assign code  = approx;

  assert_probe_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(probe));
  assert_bits_kept_R7: assert property (@(posedge clk) disable iff (rst)
    step && !load |=> (approx & $past(approx)) == $past(approx));
endmodule

// File: rtl/adc_sel_shadow.sv
module adc_sel_shadow #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         open,
  output logic [W-1:0] active
);
  logic [W-1:0] temp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      temp_q <= '0;
      active <= '0;
    end else begin
      if (wr) temp_q <= wdata;
      if (open) active <= temp_q;
    end
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int CLK_HALF = 2,
  parameter int RES_W    = 10,
  parameter int SEL_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start_wr,
  input  logic             auto_trig,
  input  logic             free_run,
  input  logic             diff_mode,
  input  logic             done_clr,
  input  logic             sel_wr,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic             cmp_keep,
  output logic             adc_clk,
  output logic             sync_clk,
  output logic             sh_strobe,
  output logic [RES_W-1:0] dac_code,
  output logic             done_flag,
  output logic             start_busy,
  output logic [RES_W-1:0] result,
  output logic [SEL_W-1:0] active_sel
);
  localparam logic [TM_W-1:0] TRIAL_SPAN = TM_W'(2 * RES_W);
  localparam logic [TM_W-1:0] LAST_SPAN  = TM_W'(2);

  logic             tick, rise;
  logic             busy, pend, pend_free, first;
  logic [TM_W-1:0]  hcnt, hnext;
  conv_tm_t         tm;
  conv_kind_t       kind;
  logic             sh_q, done_q;
  logic [RES_W-1:0] res_q, sar_code;
  logic             auto_go, user_go, fin, restart_now, go, trial_step, sel_open;

  adc_clk_div #(.HALF(CLK_HALF)) u_div (
    .clk(clk), .rst(rst), .hold(!en), .resync(auto_go),
    .tick(tick), .rise(rise), .adc_clk(adc_clk), .half_clk(sync_clk)
  );

  assign hnext       = hcnt + 1'b1;
  assign auto_go     = en && auto_trig && !busy && !pend;
  assign user_go     = en && rise && pend && !busy;
  assign fin         = busy && tick && (hnext == tm.end_at);
  assign restart_now = fin && free_run && rise;
  assign go          = auto_go || user_go || restart_now;
  assign trial_step  = busy && tick && (hnext + TRIAL_SPAN >= tm.end_at) &&
                       (hnext < tm.end_at) && (hnext[0] == tm.end_at[0]);
  assign sel_open    = !busy || (hcnt + LAST_SPAN >= tm.end_at);

  always_comb begin
    if (first)                        kind = KIND_WARM;
    else if (auto_go)                 kind = KIND_AUTO;
    else if (restart_now || pend_free) kind = diff_mode ? KIND_LONG : KIND_BASE;
    else                              kind = (diff_mode && sync_clk) ? KIND_LONG : KIND_BASE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      pend      <= 1'b0;
      pend_free <= 1'b0;
      first     <= 1'b1;
      hcnt      <= '0;
      tm        <= tm_of(KIND_BASE);
      sh_q      <= 1'b0;
      done_q    <= 1'b0;
      res_q     <= '0;
    end else if (!en) begin
      busy      <= 1'b0;
      pend      <= 1'b0;
      pend_free <= 1'b0;
      first     <= 1'b1;
      sh_q      <= 1'b0;
    end else begin
      sh_q <= 1'b0;
      if (done_clr) done_q <= 1'b0;
      if (start_wr && !busy) pend <= 1'b1;
      if (busy && tick) begin
        hcnt <= hnext;
        if (hnext == tm.sh_at) sh_q <= 1'b1;
      end
      if (fin) begin
        busy   <= 1'b0;
        done_q <= 1'b1;
        res_q  <= sar_code;
        if (free_run && !rise) begin
          pend      <= 1'b1;
          pend_free <= 1'b1;
        end
      end
      if (go) begin
        busy      <= 1'b1;
        hcnt      <= '0;
        tm        <= tm_of(kind);
        pend      <= 1'b0;
        pend_free <= 1'b0;
        first     <= 1'b0;
      end
    end
  end

  adc_sar_reg #(.W(RES_W)) u_sar (
    .clk(clk), .rst(rst), .load(go), .step(trial_step), .keep(cmp_keep),
    .trial(dac_code), .code(sar_code)
  );

  adc_sel_shadow #(.W(SEL_W)) u_sel (
    .clk(clk), .rst(rst), .wr(sel_wr), .wdata(sel_wdata),
    .open(sel_open), .active(active_sel)
  );

  assign sh_strobe  = sh_q;
  assign done_flag  = done_q;
  assign start_busy = busy || pend;
  assign result     = res_q;

  assert_done_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> $past(busy));
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    done_flag && !done_clr |=> done_flag);
  assert_strobe_in_conv_R2: assert property (@(posedge clk) disable iff (rst)
    sh_strobe |-> busy);
  assert_sel_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) && ($past(hcnt) + LAST_SPAN < $past(tm.end_at))
      |-> $stable(active_sel));
  assert_abort_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !start_busy);
endmodule

// File: tb/sim_adc_conv_seq.sv
`timescale 1ns/1ps
module sim_adc_conv_seq;
  localparam int HALF = 2;

  typedef struct {
    string tag;
    int    cs;
    int    hs;
    int    hl;
    int    res;
  } exp_t;

  logic clk = 1'b0;
  logic rst, en, start_wr, auto_trig, free_run, diff_mode, done_clr, sel_wr;
  logic [4:0] sel_wdata;
  logic cmp_keep;
  logic adc_clk, sync_clk, sh_strobe, done_flag, start_busy;
  logic [9:0] dac_code, result;
  logic [4:0] active_sel;

  int analog = 0;
  int cyc = 0;
  int nchk = 0;
  int nbad = 0;
  int last_sh = 0;
  bit done_prev = 1'b0;
  bit first_exp = 1'b0;
  int seen_hi = 0;
  int seen_lo = 0;
  exp_t q[$];
  exp_t mon_e;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign cmp_keep = (int'(dac_code) <= analog);

  adc_conv_seq u0 (
    .clk(clk), .rst(rst), .en(en), .start_wr(start_wr), .auto_trig(auto_trig),
    .free_run(free_run), .diff_mode(diff_mode), .done_clr(done_clr),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata), .cmp_keep(cmp_keep),
    .adc_clk(adc_clk), .sync_clk(sync_clk), .sh_strobe(sh_strobe),
    .dac_code(dac_code), .done_flag(done_flag), .start_busy(start_busy),
    .result(result), .active_sel(active_sel)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected item on each done rise
  always @(negedge clk) begin
    if (sh_strobe) last_sh = cyc;
    if (done_flag && !done_prev) begin
      if (q.size() == 0) chk(1'b0, "R8 done with nothing expected", 1, 0);
      else begin
        mon_e = q.pop_front();
        chk(result == 10'(mon_e.res), {mon_e.tag, " result"}, int'(result), mon_e.res);
        chk(last_sh - mon_e.cs == mon_e.hs * HALF, {mon_e.tag, " strobe time"},
            last_sh - mon_e.cs, mon_e.hs * HALF);
        chk(cyc - mon_e.cs == mon_e.hl * HALF, {mon_e.tag, " done time"},
            cyc - mon_e.cs, mon_e.hl * HALF);
      end
    end
    done_prev = done_flag;
  end

  task automatic start_conv(input bit d, input int an, input string tag);
    int a, s;
    exp_t e;
    analog = an;
    diff_mode = d;
    @(negedge clk); start_wr = 1'b1;
    @(negedge clk); start_wr = 1'b0;
    chk(start_busy == 1'b1, "R8 start bit reads 1", int'(start_busy), 1);
    a = adc_clk; s = sync_clk;
    while (1) begin
      @(negedge clk);
      if (!a && adc_clk) break;
      a = adc_clk; s = sync_clk;
    end
    e.cs = cyc; e.res = an; e.tag = tag;
    if (first_exp) begin e.hs = 27; e.hl = 50; end
    else if (d && s != 0) begin e.hs = 5; e.hl = 28; seen_hi++; end
    else begin e.hs = 3; e.hl = 26; if (d) seen_lo++; end
    first_exp = 1'b0;
    q.push_back(e);
  endtask

  task automatic finish_conv(input string tag);
    while (!done_flag) @(negedge clk);
    chk(start_busy == 1'b0, {tag, " R8 start bit clears"}, int'(start_busy), 0);
    repeat (3) @(negedge clk);
    chk(done_flag == 1'b1, "R8 done sticky", int'(done_flag), 1);
    done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
    chk(done_flag == 1'b0, "R8 done cleared", int'(done_flag), 0);
  endtask

  task automatic wait_rise_sync(input bit want);
    int a;
    a = adc_clk;
    while (1) begin
      @(negedge clk);
      if (!a && adc_clk && sync_clk == want) break;
      a = adc_clk;
    end
  endtask

  task automatic run_free(input bit d, input int n, input int an);
    exp_t e;
    free_run = 1'b1;
    start_conv(d, an, d ? "R6 free diff lead" : "R6 free single lead");
    for (int i = 1; i < n; i++) begin
      while (!done_flag) @(negedge clk);
      e.cs = cyc; e.res = an;
      e.hs = d ? 5 : 3; e.hl = d ? 28 : 26;
      e.tag = d ? "R6 diff restart" : "R6 single restart";
      q.push_back(e);
      chk(start_busy == 1'b1, "R6 restart immediate", int'(start_busy), 1);
      if (i == n - 1) free_run = 1'b0;
      done_clr = 1'b1;
      @(negedge clk); done_clr = 1'b0;
    end
    finish_conv("R6 last");
  endtask

  task automatic auto_conv(input int an);
    exp_t e;
    analog = an; diff_mode = 1'b0;
    @(negedge clk); auto_trig = 1'b1;
    @(negedge clk); auto_trig = 1'b0;
    e.cs = cyc; e.res = an; e.hs = 4; e.hl = 27; e.tag = "R4 auto";
    q.push_back(e);
    chk(start_busy == 1'b1, "R4 auto started", int'(start_busy), 1);
    repeat (53) @(negedge clk);
    done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
    chk(done_flag == 1'b1, "R8 set beats clear", int'(done_flag), 1);
    @(negedge clk);
    chk(done_flag == 1'b1, "R8 set beats clear, held", int'(done_flag), 1);
    finish_conv("R4");
  endtask

  initial begin
    #1_500_000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    int r1, r2, a;
    rst = 1'b1; en = 1'b0; start_wr = 1'b0; auto_trig = 1'b0; free_run = 1'b0;
    diff_mode = 1'b0; done_clr = 1'b0; sel_wr = 1'b0; sel_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(done_flag == 1'b0, "R8 reset done", int'(done_flag), 0);
    chk(start_busy == 1'b0, "R8 reset start", int'(start_busy), 0);
    chk(adc_clk == 1'b0 && sync_clk == 1'b0, "R10 clocks held while off", int'(adc_clk), 0);

    // R9: idle select follows the temporary register
    sel_wdata = 5'h0A; sel_wr = 1'b1;
    @(negedge clk); sel_wr = 1'b0;
    @(negedge clk);
    chk(active_sel == 5'h0A, "R9 idle copy", int'(active_sel), 10);

    en = 1'b1; first_exp = 1'b1;
    // R1: ADC clock period
    a = adc_clk;
    while (1) begin @(negedge clk); if (!a && adc_clk) break; a = adc_clk; end
    r1 = cyc; a = adc_clk;
    while (1) begin @(negedge clk); if (!a && adc_clk) break; a = adc_clk; end
    r2 = cyc;
    chk(r2 - r1 == 2 * HALF, "R1 adc_clk period", r2 - r1, 2 * HALF);

    start_conv(1'b0, 677, "R3 first conversion");
    finish_conv("R3");
    start_conv(1'b0, 1023, "R2 single full scale");
    finish_conv("R2");
    start_conv(1'b0, 0, "R7 zero code");
    finish_conv("R7");
    wait_rise_sync(1'b0);
    start_conv(1'b1, 341, "R5 diff sync low");
    finish_conv("R5");
    wait_rise_sync(1'b1);
    start_conv(1'b1, 682, "R5 diff sync high");
    finish_conv("R5");
    auto_conv(555);
    run_free(1'b1, 3, 200);
    run_free(1'b0, 2, 901);

    // R9: frozen during conversion, resumes before done
    start_conv(1'b0, 300, "R9 conversion");
    repeat (8) @(negedge clk);
    sel_wdata = 5'h15; sel_wr = 1'b1;
    @(negedge clk); sel_wr = 1'b0;
    repeat (4) @(negedge clk);
    chk(active_sel == 5'h0A, "R9 select frozen", int'(active_sel), 10);
    while (!done_flag) @(negedge clk);
    chk(active_sel == 5'h15, "R9 copy resumed before done", int'(active_sel), 21);
    finish_conv("R9");

    // R10: abort on disable
    @(negedge clk); start_wr = 1'b1;
    @(negedge clk); start_wr = 1'b0;
    repeat (20) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(start_busy == 1'b0, "R10 abort clears start", int'(start_busy), 0);
    chk(adc_clk == 1'b0, "R10 prescaler held", int'(adc_clk), 0);
    start_wr = 1'b1;
    @(negedge clk); start_wr = 1'b0;
    @(negedge clk);
    chk(start_busy == 1'b0, "R10 start ignored while off", int'(start_busy), 0);
    repeat (100) @(negedge clk);
    chk(done_flag == 1'b0, "R10 aborted conversion never completes", int'(done_flag), 0);
    en = 1'b1; first_exp = 1'b1;
    start_conv(1'b0, 512, "R10 first after re-enable");
    finish_conv("R10");

    chk(q.size() == 0, "R8 every conversion completed", q.size(), 0);
    chk(seen_lo > 0, "R5 sync low case covered", seen_lo, 1);
    chk(seen_hi > 0, "R5 sync high case covered", seen_hi, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule